// File: doc/BRIEF.md
# Multi-order QAM mapper modulator

This block takes one symbol's worth of data bits on each symbol strobe and turns it into a digitally modulated carrier. A Gray-coded constellation table for the selected order gives the in-phase and quadrature amplitudes. These amplitudes are held for the whole symbol period and multiply a quadrature pair of carrier samples. A single sine table supplies both samples: the sine is read at the phase index and the cosine a quarter of the table further on.

Three constellation orders are available: 4, 16 and 64 points. The order is chosen by a small code and takes effect only at a symbol boundary. The carrier phase moves forward one table step on each carrier-enable cycle, so the carrier frequency is set by the rate of that enable. A symbol change shows up on the output as a phase and/or amplitude jump. A one-cycle data-request pulse tells the upstream source that the current bits have been consumed. The output is a signed sample, scaled by an arithmetic right shift and saturated to the output width.

Top module: `qam_modulator`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `mod_out` is 0 and `data_req` is 0. The held amplitudes and the phase index reset to 0.
- R2: `data_req` is high in exactly the cycle after a clock edge that sampled `sym_stb` high, and low otherwise.
- R3: The amplitudes and the active order change only on an edge where `sym_stb` is high. Changes on `sym_bits` or `order_sel` at other times have no effect on `mod_out`.
- R4: `order_sel` codes: 0 selects 4 points (2 bits), 1 selects 16 points (4 bits), 2 selects 64 points (6 bits), and 3 behaves exactly like 0. With K bits per axis, the I field is `sym_bits[2K-1:K]` and the Q field is `sym_bits[K-1:0]`.
- R5: A field f of K bits maps to level index g = Gray-to-binary(f). Its amplitude is (2g-(L-1))·floor(AMAX/(L-1)), where L = 2^K and AMAX = 2^(AMP_W-1)-1. Neighbouring levels therefore differ in one field bit.
- R6: In 4-point mode every symbol has |I| = |Q| = AMAX, so all four states have equal amplitude and adjacent states are 90 degrees apart.
- R7: Table entry k (depth D, H = D/2, A = 2^(SIN_W-1)-1) is the truncated integer 16·p·A/(5·H²-4·p), where p = k·(H-k), for k < H. For k ≥ H it is the negative of entry k-H.
- R8: The phase index n starts at 0 and advances by one, modulo D, only on cycles with `car_en` high. The sine sample is entry n and the cosine sample is entry (n + D/4) mod D.
- R9: `mod_out` after edge e is sat((I·C + Q·S) >>> OUT_SHIFT). I and Q are the amplitudes held before edge e. S and C are the table entries for the phase index held before edge e-1.
- R10: When the shifted sum lies outside the signed OUT_W range, `mod_out` clamps to the largest or smallest representable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_bits | input | 6 | Symbol bits, right-aligned |
| order_sel | input | 2 | Constellation order code |
| sym_stb | input | 1 | Symbol boundary strobe |
| car_en | input | 1 | Carrier phase advance enable |
| mod_out | output | OUT_W | Signed modulated sample |
| data_req | output | 1 | One-cycle request for the next symbol |

## Verification
The bench builds the block with an 8-bit amplitude, a 12-bit sine table of depth 256, a shift of 8 and a 10-bit output. With these values the 4-point corners drive the sum well past the output range, so clamping is exercised often. A small 64-point symbol sweeps one carrier revolution without clamping, which exposes the table and the quarter-table cosine offset. Every point of all three orders is strobed in turn, and the reserved order code and mid-symbol input changes are tried against the same expected values.

// File: rtl/qam_pkg.sv
package qam_pkg;
  localparam int SYM_W = 6;

  typedef enum logic [1:0] {
    ORD_4  = 2'd0,
    ORD_16 = 2'd1,
    ORD_64 = 2'd2
  } qam_order_e;

  function automatic qam_order_e decode_order(input logic [1:0] code);
    case (code)
      2'd1:    return ORD_16;
      2'd2:    return ORD_64;
      default: return ORD_4;
    endcase
  endfunction

  function automatic logic [2:0] gray_to_bin(input logic [2:0] v);
    logic [2:0] r;
    r[2] = v[2];
    r[1] = v[2] ^ v[1];
    r[0] = v[2] ^ v[1] ^ v[0];
    return r;
  endfunction
endpackage

// File: rtl/qam_sine_rom.sv
module qam_sine_rom #(
  parameter int DEPTH = 256,
  parameter int DW    = 12
) (
  input  logic                     clk,
  input  logic [$clog2(DEPTH)-1:0] addr_a,
  input  logic [$clog2(DEPTH)-1:0] addr_b,
  output logic signed [DW-1:0]     rd_a,
  output logic signed [DW-1:0]     rd_b
);
  localparam int HALF = DEPTH / 2;
  localparam longint PEAK = (64'sd1 <<< (DW - 1)) - 1;

  function automatic logic signed [DW-1:0] sine_pt(input int k);
    longint kk, p, v;
    kk = (k < HALF) ? longint'(k) : longint'(k - HALF);
    p  = kk * (HALF - kk);
    v  = (16 * p * PEAK) / (5 * longint'(HALF) * HALF - 4 * p);
    if (k >= HALF) v = -v;
    return DW'(v);
  endfunction

  logic signed [DW-1:0] mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) mem[k] = sine_pt(k);
  end

  always_ff @(posedge clk) begin
    rd_a <= mem[addr_a];
    rd_b <= mem[addr_b];
  end
endmodule

// File: rtl/qam_carrier_gen.sv
module qam_carrier_gen #(
  parameter int SIN_W     = 12,
  parameter int TBL_DEPTH = 256
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    car_en,
  output logic signed [SIN_W-1:0] sin_s,
  output logic signed [SIN_W-1:0] cos_s
);
  localparam int AW = $clog2(TBL_DEPTH);
  localparam logic [AW-1:0] QUARTER = AW'(TBL_DEPTH / 4);

  logic [AW-1:0] phase;
  logic [AW-1:0] cos_idx;

  always_ff @(posedge clk) begin
    if (rst)         phase <= '0;
    else if (car_en) phase <= phase + 1'b1;
  end

  assign cos_idx = phase + QUARTER;

  qam_sine_rom #(.DEPTH(TBL_DEPTH), .DW(SIN_W)) u_rom (
    .clk   (clk),
    .addr_a(phase),
    .addr_b(cos_idx),
    .rd_a  (sin_s),
    .rd_b  (cos_s)
  );
endmodule

// File: rtl/qam_symbol_map.sv
module qam_symbol_map
  import qam_pkg::*;
#(
  parameter int AMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sym_stb,
  input  logic [SYM_W-1:0]        sym_bits,
  input  logic [1:0]              order_sel,
  output logic signed [AMP_W-1:0] i_amp,
  output logic signed [AMP_W-1:0] q_amp
);
  localparam int AMAX   = (1 << (AMP_W - 1)) - 1;
  localparam int N_ORD  = 3;

  logic signed [AMP_W-1:0] i_sel [N_ORD];
  logic signed [AMP_W-1:0] q_sel [N_ORD];

  for (genvar g = 0; g < N_ORD; g++) begin : g_order
    localparam int K    = g + 1;
    localparam int LV   = 1 << K;
    localparam int STEP = AMAX / (LV - 1);

    logic signed [AMP_W-1:0] i_tbl [LV];
    logic signed [AMP_W-1:0] q_tbl [LV];
    logic [K-1:0] gi, gq;

    for (genvar e = 0; e < LV; e++) begin : g_lvl
      assign i_tbl[e] = AMP_W'((2 * e - (LV - 1)) * STEP);
      assign q_tbl[e] = AMP_W'((2 * e - (LV - 1)) * STEP);
    end

    assign gi = K'(gray_to_bin(3'(sym_bits[2*K-1:K])));
    assign gq = K'(gray_to_bin(3'(sym_bits[K-1:0])));
    assign i_sel[g] = i_tbl[gi];
    assign q_sel[g] = q_tbl[gq];
  end

  qam_order_e ord_now;
  assign ord_now = decode_order(order_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      i_amp <= '0;
      q_amp <= '0;
    end else if (sym_stb) begin
      case (ord_now)
        ORD_16:  begin i_amp <= i_sel[1]; q_amp <= q_sel[1]; end
        ORD_64:  begin i_amp <= i_sel[2]; q_amp <= q_sel[2]; end
        default: begin i_amp <= i_sel[0]; q_amp <= q_sel[0]; end
      endcase
    end
  end
endmodule

// File: rtl/qam_modulator.sv
module qam_modulator #(
  parameter int AMP_W     = 8,
  parameter int SIN_W     = 12,
  parameter int OUT_W     = 12,
  parameter int OUT_SHIFT = 8,
  parameter int TBL_DEPTH = 256
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [qam_pkg::SYM_W-1:0]      sym_bits,
  input  logic [1:0]                     order_sel,
  input  logic                           sym_stb,
  input  logic                           car_en,
  output logic signed [OUT_W-1:0]        mod_out,
  output logic                           data_req
);
  localparam int PW = AMP_W + SIN_W + 1;
  localparam logic signed [PW-1:0] OMAX = PW'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [PW-1:0] OMIN = PW'(-(2 ** (OUT_W - 1)));

  logic signed [AMP_W-1:0] i_amp, q_amp;
  logic signed [SIN_W-1:0] sin_s, cos_s;
  logic signed [PW-1:0]    prod_i, prod_q, mix_sum, mix_scaled;
  logic signed [PW-1:0]    mix_sat;

  qam_symbol_map #(.AMP_W(AMP_W)) u_map (
    .clk      (clk),
    .rst      (rst),
    .sym_stb  (sym_stb),
    .sym_bits (sym_bits),
    .order_sel(order_sel),
    .i_amp    (i_amp),
    .q_amp    (q_amp)
  );

  qam_carrier_gen #(.SIN_W(SIN_W), .TBL_DEPTH(TBL_DEPTH)) u_car (
    .clk   (clk),
    .rst   (rst),
    .car_en(car_en),
    .sin_s (sin_s),
    .cos_s (cos_s)
  );

  always_comb begin
    prod_i     = PW'(i_amp) * PW'(cos_s);
    prod_q     = PW'(q_amp) * PW'(sin_s);
    mix_sum    = prod_i + prod_q;
    mix_scaled = mix_sum >>> OUT_SHIFT;
    if (mix_scaled > OMAX)      mix_sat = OMAX;
    else if (mix_scaled < OMIN) mix_sat = OMIN;
    else                        mix_sat = mix_scaled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_out  <= '0;
      data_req <= 1'b0;
    end else begin
      mod_out  <= OUT_W'(mix_sat);
      data_req <= sym_stb;
    end
  end
endmodule

// File: rtl/qam_modulator_chk.sv
module qam_modulator_chk #(
  parameter int AMP_W = 8,
  parameter int SIN_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sym_stb,
  input logic [1:0]              order_sel,
  input logic                    car_en,
  input logic                    data_req,
  input logic signed [AMP_W-1:0] i_amp,
  input logic signed [AMP_W-1:0] q_amp,
  input logic signed [SIN_W-1:0] sin_s
);
  localparam logic signed [AMP_W-1:0] AMAX = AMP_W'((2 ** (AMP_W - 1)) - 1);

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    sym_stb |=> data_req);

  assert_req_only_R2: assert property (@(posedge clk) disable iff (rst)
    data_req |-> $past(sym_stb));

  assert_iq_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(sym_stb) |-> ($stable(i_amp) && $stable(q_amp)));

  assert_qam4_equal_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(sym_stb) && $past(order_sel) != 2'd1 && $past(order_sel) != 2'd2)
    |-> ((i_amp == AMAX || i_amp == -AMAX) && (q_amp == AMAX || q_amp == -AMAX)));

  assert_carrier_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(car_en, 2) && !$past(rst, 2)) |-> $stable(sin_s));
endmodule

bind qam_modulator qam_modulator_chk #(.AMP_W(AMP_W), .SIN_W(SIN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sym_stb  (sym_stb),
  .order_sel(order_sel),
  .car_en   (car_en),
  .data_req (data_req),
  .i_amp    (i_amp),
  .q_amp    (q_amp),
  .sin_s    (sin_s)
);

// File: tb/qam_modulator_tb_top.sv
module qam_modulator_tb_top;
  localparam int AMP_W = 8, SIN_W = 12, OUT_W = 10, OUT_SHIFT = 8, DEPTH = 256;
  localparam int AMAX = (1 << (AMP_W - 1)) - 1;
  localparam int SPK  = (1 << (SIN_W - 1)) - 1;
  localparam int OMAX = (1 << (OUT_W - 1)) - 1;
  localparam int OMIN = -(1 << (OUT_W - 1));

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] sym_bits = '0;
  logic [1:0] order_sel = '0;
  logic sym_stb = 1'b0, car_en = 1'b0;
  logic signed [OUT_W-1:0] mod_out;
  logic data_req;

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R9";
  bit done = 0;

  always #2.5 clk = ~clk;

  qam_modulator #(.AMP_W(AMP_W), .SIN_W(SIN_W), .OUT_W(OUT_W),
                  .OUT_SHIFT(OUT_SHIFT), .TBL_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .sym_bits(sym_bits), .order_sel(order_sel),
    .sym_stb(sym_stb), .car_en(car_en), .mod_out(mod_out), .data_req(data_req));

  function automatic int b_sine(input int k);
    longint kk, p, v;
    kk = (k < DEPTH / 2) ? k : k - DEPTH / 2;
    p  = kk * (DEPTH / 2 - kk);
    v  = (16 * p * SPK) / (5 * longint'(DEPTH / 2) * (DEPTH / 2) - 4 * p);
    return (k < DEPTH / 2) ? int'(v) : -int'(v);
  endfunction

  function automatic int b_bits_axis(input logic [1:0] o);
    return (o == 2'd1) ? 2 : (o == 2'd2) ? 3 : 1;
  endfunction

  function automatic int b_level(input int f, input int k);
    int g, lv;
    g = f;
    for (int s = 1; s < 3; s++) g = g ^ (f >> s);
    lv = 1 << k;
    return (2 * g - (lv - 1)) * (AMAX / (lv - 1));
  endfunction

  function automatic int b_i(input logic [5:0] b, input logic [1:0] o);
    int k = b_bits_axis(o);
    return b_level((int'(b) >> k) & ((1 << k) - 1), k);
  endfunction

  function automatic int b_q(input logic [5:0] b, input logic [1:0] o);
    int k = b_bits_axis(o);
    return b_level(int'(b) & ((1 << k) - 1), k);
  endfunction

  // reference pipeline derived from R8/R9 latencies
  int m_i, m_q, m_n, m_s, m_c, m_out;
  bit m_req, m_satf;
  always @(posedge clk) begin
    int pre;
    pre = (m_i * m_c + m_q * m_s) >>> OUT_SHIFT;
    if (rst) begin
      m_i <= 0; m_q <= 0; m_n <= 0; m_out <= 0; m_req <= 0; m_satf <= 0;
    end else begin
      m_req <= sym_stb;
      if (sym_stb) begin
        m_i <= b_i(sym_bits, order_sel);
        m_q <= b_q(sym_bits, order_sel);
      end
      if (car_en) m_n <= (m_n + 1) % DEPTH;
      m_out  <= (pre > OMAX) ? OMAX : (pre < OMIN) ? OMIN : pre;
      m_satf <= (pre > OMAX) || (pre < OMIN);
    end
    m_s <= b_sine(m_n);
    m_c <= b_sine((m_n + DEPTH / 4) % DEPTH);
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (int'(mod_out) != m_out) begin
        n_fail++;
        $display("FAIL %s mod_out actual %0d expected %0d", m_satf ? "R10" : cur_tag,
                 mod_out, m_out);
      end
      n_chk++;
      if (data_req !== m_req) begin
        n_fail++;
        $display("FAIL R2 data_req actual %0b expected %0b", data_req, m_req);
      end
    end
  end

  task automatic step(input logic stb, input logic [5:0] b, input logic [1:0] o,
                      input logic ce);
    sym_stb = stb; sym_bits = b; order_sel = o; car_en = ce;
    @(negedge clk);
  endtask

  task automatic send(input logic [5:0] b, input logic [1:0] o, input int hold,
                      input bit rnd_ce);
    step(1'b1, b, o, rnd_ce ? 1'($urandom % 2) : 1'b1);
    for (int c = 0; c < hold; c++) step(1'b0, b, o, rnd_ce ? 1'($urandom % 2) : 1'b1);
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'h0a51_7e3d);
    repeat (6) @(negedge clk);
    rst = 1'b0;
    n_chk++;
    if (mod_out !== '0 || data_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 after reset actual %0d/%0b expected 0/0", mod_out, data_req);
    end
    step(1'b0, 6'h3f, 2'd2, 1'b0);

    cur_tag = "R6";
    for (int s = 0; s < 4; s++) send(6'(s), 2'd0, 20, 0);

    cur_tag = "R5";
    for (int s = 0; s < 16; s++) send(6'(s), 2'd1, 6, 1);
    for (int s = 0; s < 64; s++) send(6'(s), 2'd2, 6, 1);

    cur_tag = "R4";
    for (int s = 0; s < 8; s++) send(6'($urandom), 2'd3, 5, 1);

    cur_tag = "R3";
    send(6'b000001, 2'd0, 0, 1);
    for (int c = 0; c < 12; c++) step(1'b0, 6'($urandom), 2'($urandom), 1'b1);

    cur_tag = "R8";
    for (int c = 0; c < 20; c++) step(1'b0, 6'h0, 2'd0, 1'b0);
    for (int c = 0; c < 60; c++) step(1'b0, 6'h0, 2'd0, 1'(c % 3 == 0));

    cur_tag = "R7";
    send(6'b110010, 2'd2, 300, 0);

    cur_tag = "R9";
    for (int c = 0; c < 3000; c++)
      step(1'(($urandom % 8) == 0), 6'($urandom), 2'($urandom), 1'($urandom % 2));

    cur_tag = "R10";
    send(6'b000011, 2'd0, 40, 0);
    send(6'b000000, 2'd0, 40, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule